// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a 32-bit register port. A transmit word is loaded into a small transmit queue. A single command write then sets the frame length, the clock mode, the target chip-select line and the direction enables, and starts the frame with its top bit. The shift engine divides the system clock down to SCLK. It sends the frame most-significant-bit first and assembles the received bits right-aligned. It pushes the received word into a small receive queue and raises a ready flag that software clears by writing one.

Queue misuse leaves sticky error flags in the queue status register. These are an underrun on either side and an overflow on either side. A summary error bit shows whether any of them is set. Software can also take the selected chip-select line out of the engine's hands and drive it to a chosen level, which holds a line low across several frames.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the command register reads 0x0010_0000, transfer status reads 0, queue status reads 0x0000_0005, the divider reads 1, all four chip-select lines are high and SCLK is low.
- R2: Byte offsets are 0x000 command, 0x010 transfer status, 0x014 queue status, 0x108 transmit port (write), 0x188 receive port (read) and 0x18C divider; read data appears one clock after the read strobe. Writing command bit 31 as 1 starts one frame; bit 31 reads 1 while a frame runs, and writes to the command and divider registers during a frame are ignored.
- R3: Command bits 4:0 hold the frame length minus one (1 to 32 bits); a frame produces exactly twice that many SCLK transitions.
- R4: Command bits 27:26 select one of four active-low chip-select lines. With bit 21 clear the selected line is low only while a frame runs; with bit 21 set the selected line follows bit 20. Unselected lines stay high.
- R5: Command bits 29:28 give the mode {CPOL, CPHA}: SCLK idles at CPOL; with CPHA 0 both ends sample on the first edge of each bit, with CPHA 1 on the second.
- R6: Transmit bit N-1 of the right-aligned word goes out first; higher bits are not sent. The received word is right-aligned, with the first received bit at position N-1 and all bits above N-1 zero.
- R7: Transfer status bit 30 sets when a frame completes and clears when 1 is written to it.
- R8: Command bit 12 enables receive: the received word is pushed only when it is set. Command bit 11 enables transmit: when set, start pops one transmit word; when clear, zeros are shifted and the transmit queue is untouched.
- R9: Queue status bit 0 is receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full; each queue holds 4 words.
- R10: Sticky flags in queue status: bit 4 is set by reading the empty receive port, which returns 0. Bit 5 is set when a frame completes into a full receive queue, and the word is dropped. Bit 6 is set when a frame starts with transmit enabled and an empty transmit queue, and zeros are shifted. Bit 7 is set by writing the full transmit port, and the word is dropped.
- R11: Queue status bit 8 is the OR of bits 7:4; writing 1 to any of bits 7:4 clears that flag alone.
- R12: Divider bits 7:0 hold H; every SCLK half period lasts H+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 9 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after the read strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip-select lines |

## Verification
A wrong edge index or a stale shift register changes the bits that an independent slave model captures, or shows as a wrong number of SCLK transitions. Both are visible within the frame in which the fault occurs. A queue pointer or count that goes astray shows up at the next status read as wrong empty or full bits. It also shows up at the next receive read as a word out of order. A sticky flag set or cleared at the wrong moment shows at the first status read after the triggering access. Idle-level and pacing faults on SCLK appear one clock after the offending state, and the embedded properties catch them there.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 5;
  localparam int ADDR_W = 9;

  localparam logic [ADDR_W-1:0] OFS_CMD   = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_XSTAT = 9'h010;
  localparam logic [ADDR_W-1:0] OFS_QSTAT = 9'h014;
  localparam logic [ADDR_W-1:0] OFS_TXP   = 9'h108;
  localparam logic [ADDR_W-1:0] OFS_RXP   = 9'h188;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 9'h18C;

  // sticky flag order, lowest first: rx underrun, rx overflow, tx underrun, tx overflow
  typedef struct packed {
    logic tx_ovf;
    logic tx_unr;
    logic rx_ovf;
    logic rx_unr;
  } sticky_t;

  // move a right-aligned frame of len_m1+1 bits to the top of the word
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] w,
                                                    input logic [LEN_W-1:0] len_m1);
    return w << (5'd31 - len_m1);
  endfunction

  function automatic logic [WORD_W-1:0] qstat_word(input sticky_t st, input logic tx_full,
                                                   input logic tx_empty, input logic rx_full,
                                                   input logic rx_empty);
    return {23'd0, |st, st, tx_full, tx_empty, rx_full, rx_empty};
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n) !(push && full)); // R10
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !(pop && empty)); // R10
endmodule

// File: rtl/spim_engine.sv
module spim_engine import spim_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi
);
  localparam int EDGE_W = LEN_W + 1;

  logic [DIV_W-1:0]  tick_cnt;
  logic [EDGE_W-1:0] edge_idx, last_edge;
  logic              cpha_q;
  logic [WORD_W-1:0] tx_sh, rx_sh, aligned, rx_next;
  logic              tick, lead, smp_edge, shf_edge, last;

  assign aligned  = left_align(tx_word, len_m1);
  assign tick     = busy && (tick_cnt == '0);
  assign lead     = ~edge_idx[0];
  assign smp_edge = tick && (lead ^ cpha_q);
  assign shf_edge = tick && !(lead ^ cpha_q);
  assign last     = (edge_idx == last_edge);
  assign rx_next  = {rx_sh[WORD_W-2:0], miso};
  assign done     = tick && last;
  assign rx_word  = smp_edge ? rx_next : rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      tick_cnt  <= '0;
      edge_idx  <= '0;
      last_edge <= '0;
      cpha_q    <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
    end else if (!busy) begin
      sclk <= cpol;
      if (start) begin
        busy      <= 1'b1;
        cpha_q    <= cpha;
        last_edge <= {len_m1, 1'b1};
        edge_idx  <= '0;
        tick_cnt  <= div_half;
        rx_sh     <= '0;
        if (cpha) begin
          tx_sh <= aligned;
          mosi  <= 1'b0;
        end else begin
          tx_sh <= {aligned[WORD_W-2:0], 1'b0};
          mosi  <= aligned[WORD_W-1];
        end
      end
    end else if (tick) begin
      sclk     <= ~sclk;
      tick_cnt <= div_half;
      edge_idx <= edge_idx + 1'b1;
      if (smp_edge) rx_sh <= rx_next;
      if (shf_edge) begin
        mosi  <= tx_sh[WORD_W-1];
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
      if (last) busy <= 1'b0;
    end else begin
      tick_cnt <= tick_cnt - 1'b1;
    end
  end

  AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sclk == $past(cpol))); // R5
  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R3
  AST_SCLK_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk)); // R12
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl import spim_pkg::*; #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [3:0]        spi_cs_n
);
  localparam int CS_LINES = 4;
  localparam int SEL_W    = $clog2(CS_LINES);

  // command fields
  logic [1:0]       mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             cs_sw_q, cs_lvl_q, rx_en_q, tx_en_q;
  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] div_q;
  logic             rdy_q;
  sticky_t          st_q, st_set;

  // engine and queue wires
  logic              eng_busy, frame_done;
  logic [WORD_W-1:0] eng_rx, tx_head, rx_head, eng_tx;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push, tx_pop, rx_push, rx_pop;

  // named bus events
  logic wr_cmd, go, wr_txp, wr_xstat, wr_qstat, wr_div, rd_rxp;
  logic tx_ovf_evt, tx_unr_evt, rx_ovf_evt, rx_unr_evt;

  assign wr_cmd   = reg_wr && (reg_addr == OFS_CMD) && !eng_busy;
  assign go       = wr_cmd && reg_wdata[31];
  assign wr_txp   = reg_wr && (reg_addr == OFS_TXP);
  assign wr_xstat = reg_wr && (reg_addr == OFS_XSTAT);
  assign wr_qstat = reg_wr && (reg_addr == OFS_QSTAT);
  assign wr_div   = reg_wr && (reg_addr == OFS_DIV) && !eng_busy;
  assign rd_rxp   = reg_rd && (reg_addr == OFS_RXP);

  assign tx_push    = wr_txp && !tx_full;
  assign tx_ovf_evt = wr_txp && tx_full;
  assign tx_pop     = go && reg_wdata[11] && !tx_empty;
  assign tx_unr_evt = go && reg_wdata[11] && tx_empty;
  assign rx_push    = frame_done && rx_en_q && !rx_full;
  assign rx_ovf_evt = frame_done && rx_en_q && rx_full;
  assign rx_pop     = rd_rxp && !rx_empty;
  assign rx_unr_evt = rd_rxp && rx_empty;

  assign st_set = '{tx_ovf: tx_ovf_evt, tx_unr: tx_unr_evt,
                    rx_ovf: rx_ovf_evt, rx_unr: rx_unr_evt};
  assign eng_tx = tx_pop ? tx_head : '0;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[25:22], reg_wdata[19:13], reg_wdata[10:5]};

  spim_fifo #(.DW(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk, .rst_n, .push(tx_push), .wdata(reg_wdata), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.DW(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .wdata(eng_rx), .pop(rx_pop),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty));

  spim_engine #(.DIV_W(DIV_W)) u_eng (
    .clk, .rst_n, .start(go),
    .cpol(go ? reg_wdata[29] : mode_q[1]),
    .cpha(go ? reg_wdata[28] : mode_q[0]),
    .len_m1(go ? reg_wdata[4:0] : len_q),
    .tx_word(eng_tx), .div_half(div_q), .miso(spi_miso),
    .busy(eng_busy), .done(frame_done), .rx_word(eng_rx),
    .sclk(spi_sclk), .mosi(spi_mosi));

  // chip-select lines
  for (genvar i = 0; i < CS_LINES; i++) begin : g_cs
    logic hit;
    assign hit         = (sel_q == SEL_W'(i));
    assign spi_cs_n[i] = !(hit && (cs_sw_q ? !cs_lvl_q : eng_busy));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      sel_q    <= '0;
      cs_sw_q  <= 1'b0;
      cs_lvl_q <= 1'b1;
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      len_q    <= '0;
      div_q    <= DIV_W'(1);
      rdy_q    <= 1'b0;
      st_q     <= '0;
    end else begin
      if (wr_cmd) begin
        mode_q   <= reg_wdata[29:28];
        sel_q    <= reg_wdata[27:26];
        cs_sw_q  <= reg_wdata[21];
        cs_lvl_q <= reg_wdata[20];
        rx_en_q  <= reg_wdata[12];
        tx_en_q  <= reg_wdata[11];
        len_q    <= reg_wdata[4:0];
      end
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
      rdy_q <= (rdy_q && !(wr_xstat && reg_wdata[30])) || frame_done;
      st_q  <= (st_q & ~(wr_qstat ? sticky_t'(reg_wdata[7:4]) : sticky_t'(4'b0))) | st_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        OFS_CMD:   reg_rdata <= {eng_busy, 1'b0, mode_q, sel_q, 4'd0, cs_sw_q, cs_lvl_q,
                                 7'd0, rx_en_q, tx_en_q, 6'd0, len_q};
        OFS_XSTAT: reg_rdata <= {1'b0, rdy_q, 30'd0};
        OFS_QSTAT: reg_rdata <= qstat_word(st_q, tx_full, tx_empty, rx_full, rx_empty);
        OFS_RXP:   reg_rdata <= rx_empty ? '0 : rx_head;
        OFS_DIV:   reg_rdata <= WORD_W'(div_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n)); // R4
  AST_READY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rdy_q); // R7
  AST_CMD_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> ($stable(len_q) && $stable(mode_q))); // R2
  AST_TXOVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.tx_ovf) |-> $past(wr_txp && tx_full)); // R10
  AST_RX_FILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_empty) |-> $past(frame_done && rx_en_q)); // R8
endmodule

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/100ps
module spim_ctrl_tb;
  localparam logic [8:0] A_CMD = 9'h000, A_XST = 9'h010, A_QST = 9'h014,
                         A_TXP = 9'h108, A_RXP = 9'h188, A_DIV = 9'h18C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spim_ctrl u_dut (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
                   .spi_sclk, .spi_mosi, .spi_miso, .spi_cs_n);

  // slave model
  logic s_on = 1'b0, s_cpha = 1'b0;
  int s_idx = 0, s_edges = 0;
  logic [31:0] s_tx = '0, s_rx = '0;
  logic [3:0] s_cs = '1;
  realtime s_t0 = 0, s_t1 = 0;
  logic miso_q = 1'b0;
  assign spi_miso = miso_q;

  always @(spi_sclk) if (s_on) begin
    if (s_edges == 0) begin s_cs = spi_cs_n; s_t0 = $realtime; end
    if (s_edges == 1) s_t1 = $realtime;
    if (((s_edges % 2) == 0) != s_cpha) s_rx = {s_rx[30:0], spi_mosi};
    else if (s_idx >= 0) begin miso_q = s_tx[s_idx]; s_idx--; end
    s_edges++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input logic go, input logic [1:0] mode, input logic [1:0] sel,
                                       input logic sw, input logic lvl, input logic rx,
                                       input logic tx, input logic [4:0] lm1);
    logic [31:0] c;
    c = '0;
    c[31] = go; c[29:28] = mode; c[27:26] = sel; c[21] = sw; c[20] = lvl;
    c[12] = rx; c[11] = tx; c[4:0] = lm1;
    return c;
  endfunction

  function automatic logic [31:0] low_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic frame_begin(input logic [1:0] mode, input logic [4:0] lm1, input logic [1:0] sel,
                             input logic rx, input logic tx, input logic [31:0] stx);
    int n;
    n = int'(lm1) + 1;
    wr(A_CMD, cmdw(1'b0, mode, sel, 1'b0, 1'b1, rx, tx, lm1));
    repeat (2) @(negedge clk);
    s_cpha = mode[0]; s_edges = 0; s_rx = '0; s_tx = stx;
    if (!mode[0]) begin miso_q = stx[n-1]; s_idx = n - 2; end
    else begin miso_q = 1'b0; s_idx = n - 1; end
    s_on = 1'b1;
    wr(A_CMD, cmdw(1'b1, mode, sel, 1'b0, 1'b1, rx, tx, lm1));
  endtask

  task automatic frame_end();
    logic [31:0] d;
    int k;
    k = 0;
    d = '0;
    while (k < 3000 && !d[30]) begin rd(A_XST, d); k++; end
    chk("R7 ready set", {31'd0, d[30]}, 32'd1);
    s_on = 1'b0;
    wr(A_XST, 32'h4000_0000);
  endtask

  task automatic frame(input logic [1:0] mode, input logic [4:0] lm1, input logic [1:0] sel,
                       input logic rx, input logic tx, input logic [31:0] stx);
    frame_begin(mode, lm1, sel, rx, tx, stx);
    frame_end();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // {mode, len-1, master word, slave word}
  localparam logic [70:0] VECS [6] = '{
    {2'd0, 5'd7,  32'h0000_00A5, 32'h0000_003C},
    {2'd1, 5'd15, 32'h0000_1234, 32'h0000_BEEF},
    {2'd2, 5'd31, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
    {2'd3, 5'd0,  32'h0000_0001, 32'h0000_0001},
    {2'd0, 5'd11, 32'hFFFF_F9A5, 32'h0000_0C3F},
    {2'd3, 5'd23, 32'h00AB_CDEF, 32'h0012_3456}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CMD, d); chk("R1 command reset", d, 32'h0010_0000);
    rd(A_XST, d); chk("R1 xfer status reset", d, 32'h0);
    rd(A_QST, d); chk("R1 queue status reset", d, 32'h5);
    rd(A_DIV, d); chk("R1 divider reset", d, 32'h1);
    chk("R1 cs lines", {28'd0, spi_cs_n}, 32'hF);
    chk("R1 sclk low", {31'd0, spi_sclk}, 32'd0);

    // vector table: R3 R5 R6 R4 hardware select
    for (int v = 0; v < 6; v++) begin
      logic [1:0] md; logic [4:0] lm; logic [31:0] mt, st; int n;
      {md, lm, mt, st} = VECS[v];
      n = int'(lm) + 1;
      wr(A_TXP, mt);
      frame(md, lm, 2'(v), 1'b1, 1'b1, st);
      chk("R6 slave got master bits", s_rx, mt & low_mask(n));
      rd(A_RXP, d); chk("R6 received word right-aligned", d, st & low_mask(n));
      chk("R3 sclk transitions", 32'(s_edges), 32'(2 * n));
      chk("R4 hw select during frame", {28'd0, s_cs}, {28'd0, ~(4'b1 << v[1:0])});
      chk("R5 sclk idles at cpol", {31'd0, spi_sclk}, {31'd0, md[1]});
      rd(A_XST, d); chk("R7 ready cleared", d, 32'h0);
    end

    // R12 divider, R2 busy and ignored writes
    wr(A_DIV, 32'd3);
    wr(A_TXP, 32'h5A);
    frame_begin(2'd0, 5'd7, 2'd0, 1'b1, 1'b1, 32'h81);
    rd(A_CMD, d); chk("R2 busy bit", {31'd0, d[31]}, 32'd1);
    wr(A_CMD, cmdw(1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd3));
    wr(A_DIV, 32'd9);
    frame_end();
    rd(A_CMD, d); chk("R2 command write ignored in frame", {27'd0, d[4:0]}, 32'd7);
    rd(A_DIV, d); chk("R2 divider write ignored in frame", d, 32'd3);
    chk("R12 half period cycles", 32'(int'((s_t1 - s_t0) / 5.0)), 32'd4);
    rd(A_RXP, d); chk("R6 word at slow clock", d, 32'h81);
    wr(A_DIV, 32'd0);

    // R8 transmit disabled leaves queue alone, receive works
    wr(A_TXP, 32'h77);
    frame(2'd0, 5'd7, 2'd1, 1'b1, 1'b0, 32'h42);
    chk("R8 tx disabled sends zeros", s_rx, 32'h0);
    rd(A_QST, d); chk("R9 both queues hold one word", d, 32'h0);
    rd(A_RXP, d); chk("R8 rx word", d, 32'h42);
    frame(2'd0, 5'd7, 2'd1, 1'b0, 1'b1, 32'h99);
    chk("R8 queued word sent later", s_rx, 32'h77);
    rd(A_QST, d); chk("R8 rx disabled keeps rx empty", d, 32'h5);

    // R10 transmit underrun, R11 clear
    frame(2'd0, 5'd7, 2'd1, 1'b0, 1'b1, 32'h0);
    chk("R10 underrun shifts zeros", s_rx, 32'h0);
    rd(A_QST, d); chk("R10 tx underrun flag and R11 summary", d, 32'h145);
    wr(A_QST, 32'h40);
    rd(A_QST, d); chk("R11 clear tx underrun", d, 32'h5);

    // R10 transmit overflow
    for (int i = 0; i < 5; i++) wr(A_TXP, 32'h11 + 32'(i));
    rd(A_QST, d); chk("R10 tx overflow, R9 tx full", d, 32'h189);
    wr(A_QST, 32'h80);
    rd(A_QST, d); chk("R11 clear tx overflow", d, 32'h9);
    for (int i = 0; i < 4; i++) begin
      frame(2'd1, 5'd7, 2'd0, 1'b1, 1'b1, 32'hA0 + 32'(i));
      chk("R10 queued order, dropped word absent", s_rx, 32'h11 + 32'(i));
    end
    rd(A_QST, d); chk("R9 tx empty rx full", d, 32'h6);

    // R10 receive overflow plus underrun
    frame(2'd1, 5'd7, 2'd0, 1'b1, 1'b1, 32'hEE);
    rd(A_QST, d); chk("R10 rx overflow and tx underrun", d, 32'h166);
    for (int i = 0; i < 4; i++) begin
      rd(A_RXP, d); chk("R10 rx words kept in order", d, 32'hA0 + 32'(i));
    end
    rd(A_RXP, d); chk("R10 empty read returns zero", d, 32'h0);
    rd(A_QST, d); chk("R10 rx underrun flag", d, 32'h175);
    wr(A_QST, 32'h10);
    rd(A_QST, d); chk("R11 clears only its own flag", d, 32'h165);
    wr(A_QST, 32'hF0);
    rd(A_QST, d); chk("R11 all flags cleared", d, 32'h5);

    // R4 software chip-select
    wr(A_CMD, cmdw(1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7));
    @(negedge clk); chk("R4 software low on line 2", {28'd0, spi_cs_n}, 32'hB);
    wr(A_CMD, cmdw(1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 5'd7));
    @(negedge clk); chk("R4 software high", {28'd0, spi_cs_n}, 32'hF);

    summary();
  end
endmodule